// File: doc/BRIEF.md
# Serial Mixer Command Serializer

This block runs on the host side of a serially programmed eight-channel stereo mixer. It accepts channel-control requests over a ready/valid handshake and turns each one into one or two 8-bit serial frames. It drives a serial clock, a serial data line and a single active-low strobe. That strobe acts as both chip select and load, and its rising edge latches each byte at the mixer. A request carries an operation, a channel number, left and right output enables, a level and a flag that allows the address byte to be reused.

The first byte of a command selects the channel and its output routing. The second byte carries a 6-bit attenuation level. The block keeps the last level sent to each channel, so it can fade a channel by one step per request without the host tracking levels. It also keeps the last addressed channel, so a repeated level change on the same channel can leave out the address byte. Serial clock phases and the idle strobe gap are counted in system clock cycles. Two parameters set these counts, and the integrator sizes them to meet the mixer's minimum timing.

Top module: `mix_cmd_serializer`

## Requirements
- R1: An address byte is `{1, 0, 0, left, right, chan[2:0]}`, and every byte is shifted MSB first, one bit per rising edge of `ser_clk`.
- R2: A data byte is `{0, 0, level[5:0]}`. Bits 7 and 6 of `req_level` are ignored for a set operation.
- R3: Each byte has its own strobe frame: `ser_cs_n` falls, exactly 8 rising `ser_clk` edges occur, then `ser_cs_n` rises. `ser_clk` stays low while `ser_cs_n` is high.
- R4: Each `ser_clk` low phase before a rising edge and each high phase lasts exactly `HALF_DIV` system clock cycles. `ser_data` does not change while `ser_clk` is high.
- R5: `ser_cs_n` stays high for at least `CS_GAP` system clock cycles before every falling edge, including the first one after reset.
- R6: For set and fade operations, the address byte is left out only when `req_reuse` is 1 and `req_chan` equals the most recently addressed channel. Otherwise the address byte is sent and then the data byte.
- R7: Operation code 1 (route) sends a lone address byte with the requested left and right bits. It leaves the stored level of that channel unchanged.
- R8: Operation codes 2 (fade up) and 3 (fade down) send the channel's stored level plus or minus one, saturating at 63 and 0. Code 0 (set) stores and sends the masked level. All stored levels are 0 after reset.
- R9: `req_ready` is low and `busy` is high from the cycle after a request is accepted until after the final strobe rising edge of that command. A request presented while busy is ignored.
- R10: During and right after reset, `ser_cs_n` is 1, `ser_clk` is 0, `ser_data` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 2 | 0 set, 1 route, 2 fade up, 3 fade down |
| req_chan | input | CH_W | Target channel |
| req_left | input | 1 | Route channel to left output |
| req_right | input | 1 | Route channel to right output |
| req_level | input | 8 | Requested level, only bits 5..0 used |
| req_reuse | input | 1 | Allow the address byte to be left out |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_cs_n | output | 1 | Combined select and load strobe, active low |
| busy | output | 1 | Command in progress |

## Verification
Directed requests cover the masking of an out-of-range level, a reuse on the same channel against a reuse on a different channel, and a route followed by a fade. The route-then-fade case shows whether routing disturbs the stored level. Fades at 63 and 0 show whether the level saturates or wraps. A request presented while busy, followed by a check that no extra frame appears, shows whether the block ignores it. A seeded random stream of all four operations then runs against a bench model of the levels and of the last addressed channel, while a line monitor times every clock phase and strobe gap.

// File: rtl/mixser_pkg.sv
package mixser_pkg;
  localparam int LVL_W = 6;
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  typedef enum logic [1:0] {
    OP_SET   = 2'd0,
    OP_ROUTE = 2'd1,
    OP_UP    = 2'd2,
    OP_DOWN  = 2'd3
  } mix_op_e;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_LOW,
    SH_HIGH,
    SH_TAIL
  } sh_state_e;

  typedef enum logic [1:0] {
    C_IDLE,
    C_ADDR,
    C_DATA
  } cmd_state_e;

  function automatic logic [7:0] make_addr(input logic l, input logic r, input logic [2:0] ch);
    return {1'b1, 2'b00, l, r, ch};
  endfunction

  function automatic logic [7:0] make_data(input logic [LVL_W-1:0] lvl);
    return {2'b00, lvl};
  endfunction
endpackage

// File: rtl/mixser_rst_sync.sv
module mixser_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mixser_shifter.sv
module mixser_shifter
  import mixser_pkg::*;
#(
  parameter int HALF_DIV = 125,
  parameter int CS_GAP   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_start,
  input  logic [7:0] tx_byte,
  output logic       tx_take,
  output logic       tx_done,
  output logic       ser_clk,
  output logic       ser_data,
  output logic       ser_cs_n
);
  localparam int HC_W = $clog2(HALF_DIV + 1);
  localparam int GP_W = $clog2(CS_GAP + 1);
  localparam logic [HC_W-1:0] HALF_LAST = HC_W'(HALF_DIV - 1);
  localparam logic [GP_W-1:0] GAP_FULL  = GP_W'(CS_GAP);

  sh_state_e       st_q, st_d;
  logic [HC_W-1:0] cnt_q, cnt_d;
  logic [2:0]      bit_q, bit_d;
  logic [7:0]      shr_q, shr_d;
  logic [GP_W-1:0] gap_q, gap_d;
  logic            sclk_q, sclk_d;
  logic            cs_q, cs_d;
  logic            done_q, done_d;
  logic            half_end, gap_ok;

  assign half_end = (cnt_q == HALF_LAST);
  assign gap_ok   = (gap_q == GAP_FULL);
  assign tx_take  = tx_start && (st_q == SH_IDLE) && gap_ok;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    shr_d  = shr_q;
    gap_d  = gap_q;
    sclk_d = sclk_q;
    cs_d   = cs_q;
    done_d = 1'b0;
    unique case (st_q)
      SH_IDLE: begin
        if (!gap_ok) gap_d = gap_q + 1'b1;
        if (tx_take) begin
          st_d  = SH_LOW;
          cs_d  = 1'b0;
          shr_d = tx_byte;
          bit_d = 3'd0;
          cnt_d = '0;
        end
      end
      SH_LOW: begin
        if (half_end) begin
          st_d   = SH_HIGH;
          sclk_d = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SH_HIGH: begin
        if (half_end) begin
          sclk_d = 1'b0;
          cnt_d  = '0;
          if (bit_q == 3'd7) begin
            st_d = SH_TAIL;
          end else begin
            st_d  = SH_LOW;
            shr_d = {shr_q[6:0], 1'b0};
            bit_d = bit_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SH_TAIL: begin
        if (half_end) begin
          st_d   = SH_IDLE;
          cs_d   = 1'b1;
          done_d = 1'b1;
          gap_d  = '0;
          shr_d  = '0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      cnt_q  <= '0;
      bit_q  <= 3'd0;
      shr_q  <= '0;
      gap_q  <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      shr_q  <= shr_d;
      gap_q  <= gap_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      done_q <= done_d;
    end
  end

  assign ser_clk  = sclk_q;
  assign ser_data = shr_q[7];
  assign ser_cs_n = cs_q;
  assign tx_done  = done_q;

  // Independent line observers used only by the assertions below.
  logic            sclk_prev_q;
  logic [3:0]      edge_cnt_q;
  logic [HC_W-1:0] hi_run_q;
  logic [GP_W-1:0] cs_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      edge_cnt_q  <= '0;
      hi_run_q    <= '0;
      cs_run_q    <= '0;
    end else begin
      sclk_prev_q <= sclk_q;
      edge_cnt_q  <= cs_q ? 4'd0 : edge_cnt_q + {3'd0, sclk_q & ~sclk_prev_q};
      if (!sclk_q)                             hi_run_q <= '0;
      else if (hi_run_q != HC_W'(HALF_DIV))    hi_run_q <= hi_run_q + 1'b1;
      if (!cs_q)                               cs_run_q <= '0;
      else if (cs_run_q != GAP_FULL)           cs_run_q <= cs_run_q + 1'b1;
    end
  end

  assert_eight_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_cs_n) |-> edge_cnt_q == 4'd8);
  assert_clk_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_cs_n |-> !ser_clk);
  assert_high_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> hi_run_q == HC_W'(HALF_DIV));
  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
  assert_strobe_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_cs_n) |-> cs_run_q == GAP_FULL);
endmodule

// File: rtl/mixser_ctrl.sv
module mixser_ctrl
  import mixser_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [CH_W-1:0] req_chan,
  input  logic            req_left,
  input  logic            req_right,
  input  logic [7:0]      req_level,
  input  logic            req_reuse,
  output logic            busy,
  output logic            tx_start,
  output logic [7:0]      tx_byte,
  input  logic            tx_take,
  input  logic            tx_done
);
  cmd_state_e       st_q, st_d;
  logic             pend_q, pend_d;
  logic [7:0]       addr_q, addr_d;
  logic [7:0]       data_q, data_d;
  logic             need_data_q, need_data_d;
  logic [CH_W-1:0]  last_ch_q, last_ch_d;
  logic             last_v_q, last_v_d;
  logic [LVL_W-1:0] lvl_q [NUM_CH];
  logic [LVL_W-1:0] cur_lvl, new_lvl;
  logic             lvl_we;
  logic             accept, skip_addr;
  mix_op_e          op;

  assign op      = mix_op_e'(req_op);
  assign accept  = req_valid && (st_q == C_IDLE);
  assign cur_lvl = lvl_q[req_chan];

  always_comb begin
    unique case (op)
      OP_SET:   new_lvl = req_level[LVL_W-1:0];
      OP_UP:    new_lvl = (cur_lvl == LVL_MAX) ? LVL_MAX : cur_lvl + 1'b1;
      OP_DOWN:  new_lvl = (cur_lvl == '0) ? '0 : cur_lvl - 1'b1;
      default:  new_lvl = cur_lvl;
    endcase
  end

  assign skip_addr = req_reuse && last_v_q && (req_chan == last_ch_q) && (op != OP_ROUTE);
  assign lvl_we    = accept && (op != OP_ROUTE);

  always_comb begin
    st_d        = st_q;
    pend_d      = pend_q;
    addr_d      = addr_q;
    data_d      = data_q;
    need_data_d = need_data_q;
    last_ch_d   = last_ch_q;
    last_v_d    = last_v_q;
    if (accept) begin
      addr_d      = make_addr(req_left, req_right, 3'(req_chan));
      data_d      = make_data(new_lvl);
      need_data_d = (op != OP_ROUTE);
      pend_d      = 1'b1;
      if (skip_addr) begin
        st_d = C_DATA;
      end else begin
        st_d      = C_ADDR;
        last_ch_d = req_chan;
        last_v_d  = 1'b1;
      end
    end else if (tx_take) begin
      pend_d = 1'b0;
    end else if (tx_done) begin
      if (st_q == C_ADDR && need_data_q) begin
        st_d   = C_DATA;
        pend_d = 1'b1;
      end else begin
        st_d = C_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= C_IDLE;
      pend_q      <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
      need_data_q <= 1'b0;
      last_ch_q   <= '0;
      last_v_q    <= 1'b0;
    end else begin
      st_q        <= st_d;
      pend_q      <= pend_d;
      addr_q      <= addr_d;
      data_q      <= data_d;
      need_data_q <= need_data_d;
      last_ch_q   <= last_ch_d;
      last_v_q    <= last_v_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  lvl_q[g] <= '0;
      else if (lvl_we && req_chan == CH_W'(g))     lvl_q[g] <= new_lvl;
    end
  end

  assign busy      = (st_q != C_IDLE);
  assign req_ready = !busy;
  assign tx_start  = pend_q;
  assign tx_byte   = (st_q == C_ADDR) ? addr_q : data_q;

  assert_addr_marker_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && st_q == C_ADDR) |-> tx_byte[7]);
  assert_data_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && st_q == C_DATA) |-> tx_byte[7:6] == 2'b00);
  assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));
endmodule

// File: rtl/mix_cmd_serializer.sv
module mix_cmd_serializer #(
  parameter int NUM_CH   = 8,
  parameter int HALF_DIV = 125,
  parameter int CS_GAP   = 64,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [CH_W-1:0] req_chan,
  input  logic            req_left,
  input  logic            req_right,
  input  logic [7:0]      req_level,
  input  logic            req_reuse,
  output logic            ser_clk,
  output logic            ser_data,
  output logic            ser_cs_n,
  output logic            busy
);
  logic       rst_int_n;
  logic       tx_start, tx_take, tx_done;
  logic [7:0] tx_byte;

  mixser_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mixser_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_chan  (req_chan),
    .req_left  (req_left),
    .req_right (req_right),
    .req_level (req_level),
    .req_reuse (req_reuse),
    .busy      (busy),
    .tx_start  (tx_start),
    .tx_byte   (tx_byte),
    .tx_take   (tx_take),
    .tx_done   (tx_done)
  );

  mixser_shifter #(.HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tx_start (tx_start),
    .tx_byte  (tx_byte),
    .tx_take  (tx_take),
    .tx_done  (tx_done),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_cs_n (ser_cs_n)
  );
endmodule

// File: tb/sim_mix_cmd_serializer.sv
`timescale 1ns/1ps
module sim_mix_cmd_serializer;
  localparam int HALF = 3;
  localparam int GAP  = 5;

  logic       clk, rst_n;
  logic       req_valid, req_ready, req_left, req_right, req_reuse;
  logic [1:0] req_op;
  logic [2:0] req_chan;
  logic [7:0] req_level;
  logic       ser_clk, ser_data, ser_cs_n, busy;

  mix_cmd_serializer #(.NUM_CH(8), .HALF_DIV(HALF), .CS_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_chan(req_chan), .req_left(req_left), .req_right(req_right),
    .req_level(req_level), .req_reuse(req_reuse), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_cs_n(ser_cs_n), .busy(busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Line monitor
  logic [7:0] frames [512];
  int   nframes = 0;
  logic p_sclk, p_cs;
  int   lowrun, highrun, csrun, nb;
  logic [7:0] acc;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sclk = 1'b0; p_cs = 1'b1; lowrun = 0; highrun = 0; csrun = 0; nb = 0; acc = 8'h00;
    end else begin
      if (ser_cs_n && ser_clk) chk(1'b0, "R3", ser_clk, 0);
      if (p_cs && !ser_cs_n) begin
        chk(csrun >= GAP, "R5", csrun, GAP);
        nb = 0; acc = 8'h00; lowrun = 1;
      end else if (!ser_cs_n) begin
        if (ser_clk && !p_sclk) begin
          chk(lowrun == HALF, "R4", lowrun, HALF);
          highrun = 1; acc = {acc[6:0], ser_data}; nb++;
        end else if (!ser_clk && p_sclk) begin
          chk(highrun == HALF, "R4", highrun, HALF);
          lowrun = 1;
        end else if (ser_clk) highrun++;
        else lowrun++;
      end
      if (!p_cs && ser_cs_n) begin
        chk(nb == 8, "R3", nb, 8);
        frames[nframes % 512] = acc;
        nframes++;
        csrun = 1;
      end else if (ser_cs_n) csrun++;
      p_sclk = ser_clk;
      p_cs   = ser_cs_n;
    end
  end

  // Bench model
  logic [5:0] m_lvl [8];
  logic [2:0] m_ch;
  bit         m_v;

  task automatic do_cmd(input logic [1:0] op, input logic [2:0] ch, input logic l,
                        input logic r, input logic [7:0] lvl, input logic reuse,
                        input bit poke, input string tag);
    logic [5:0] cur, nl;
    logic [7:0] exp [2];
    int exp_n, base;
    bit skip;
    cur = m_lvl[ch];
    case (op)
      2'd0: nl = lvl[5:0];
      2'd2: nl = (cur == 6'd63) ? 6'd63 : cur + 6'd1;
      2'd3: nl = (cur == 6'd0) ? 6'd0 : cur - 6'd1;
      default: nl = cur;
    endcase
    skip = reuse && m_v && (ch == m_ch) && (op != 2'd1);
    exp_n = 0;
    if (!skip) begin
      exp[exp_n] = {1'b1, 2'b00, l, r, ch}; exp_n++;
      m_ch = ch; m_v = 1;
    end
    if (op != 2'd1) begin
      exp[exp_n] = {2'b00, nl}; exp_n++;
      m_lvl[ch] = nl;
    end
    base = nframes;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_chan = ch; req_left = l; req_right = r; req_level = lvl;
    req_reuse = reuse; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && busy, "R9", req_ready, 0);
    if (poke) begin
      repeat (2) @(negedge clk);
      req_op = 2'd0; req_chan = ch ^ 3'd1; req_level = 8'h15; req_reuse = 1'b0;
      req_valid = 1'b1;
      chk(!req_ready, "R9", req_ready, 0);
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    while (!req_ready) @(negedge clk);
    chk(nframes - base == exp_n, tag, nframes - base, exp_n);
    for (int i = 0; i < exp_n; i++)
      chk(frames[(base + i) % 512] == exp[i], tag, frames[(base + i) % 512], exp[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) m_lvl[i] = 6'd0;
    m_ch = 3'd0; m_v = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_chan = 3'd0;
    req_left = 1'b0; req_right = 1'b0; req_level = 8'h00; req_reuse = 1'b0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(ser_cs_n == 1'b1, "R10", ser_cs_n, 1);
    chk(ser_clk == 1'b0, "R10", ser_clk, 0);
    chk(ser_data == 1'b0, "R10", ser_data, 0);
    chk(req_ready == 1'b1, "R10", req_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ser_cs_n == 1'b1 && req_ready == 1'b1, "R10", ser_cs_n, 1);

    do_cmd(2'd0, 3'd5, 1'b1, 1'b0, 8'hFF, 1'b0, 0, "R1");   // 0x95 then masked 0x3F
    do_cmd(2'd0, 3'd5, 1'b1, 1'b0, 8'hC7, 1'b1, 0, "R2");   // data only, 0x07
    do_cmd(2'd0, 3'd5, 1'b0, 1'b1, 8'h2A, 1'b1, 1, "R9");   // busy request ignored
    do_cmd(2'd0, 3'd2, 1'b1, 1'b1, 8'h09, 1'b1, 0, "R6");   // new channel: both bytes
    do_cmd(2'd1, 3'd2, 1'b0, 1'b1, 8'h30, 1'b0, 0, "R7");   // lone address 0x8A
    do_cmd(2'd2, 3'd2, 1'b0, 1'b1, 8'h00, 1'b1, 0, "R7");   // level 10 shows route kept it
    do_cmd(2'd0, 3'd7, 1'b1, 1'b0, 8'h3F, 1'b0, 0, "R8");
    do_cmd(2'd2, 3'd7, 1'b1, 1'b0, 8'h00, 1'b1, 0, "R8");   // stays 63
    do_cmd(2'd3, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 0, "R8");   // stays 0
    do_cmd(2'd3, 3'd7, 1'b1, 1'b1, 8'h00, 1'b0, 0, "R8");   // 62

    for (int n = 0; n < 40; n++) begin
      logic [1:0] op;
      logic [2:0] ch;
      op = 2'($urandom % 4);
      ch = 3'($urandom % 3);
      do_cmd(op, ch, 1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), 0, "R6");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule